// File: doc/BRIEF.md
# PCM Highway Time-Slot Assigner

This block places the voice samples of eight channels onto two serial PCM highways and collects the received samples back from them. Each highway has one transmit output with its own drive enable and one receive input. All serial traffic follows an external bit clock and an 8 kHz frame sync. The block runs on a fast system clock and samples the bit clock and frame sync as ordinary synchronous inputs.

Four global settings shape the timing: the word format (8-bit companded or 16-bit linear), the serial rate (one bit per bit-clock period or one bit per two periods), which bit-clock edge is active, and a delay of 0 to 7 bit periods between frame sync and the first bit of slot 0. Each channel has its own transmit slot, receive slot, transmit highway and receive highway. For each highway the block also drives an active-low indicator that is low while that highway's output is driven.

Transmit words are taken in once per frame. Each received word is delivered with a one-cycle strobe as soon as its last bit has been sampled.

Top module: `pcm_tsa`

## Requirements
- R1: An active bit-clock edge on which frame sync is sampled high, after being low at the previous active edge, starts a frame. With a delay setting of D (0 to 7), the most significant bit of slot 0 is launched D bit periods after that edge. Bit p of the frame occupies slot p/8.
- R2: `cfgFallEdge` = 0 makes rising bit-clock edges active and 1 makes falling edges active. Data is launched and sampled only on active edges.
- R3: With `cfgHalfRate` = 1, each serial bit lasts two active edges and the frame-starting edge begins the first half. With 0, each bit lasts one edge.
- R4: In companded mode (`cfgLinear` = 0), a channel with transmit slot s sends the low byte of its transmit word in slot s, bit 7 first. Slots run up to 127, so bit 1023 of the frame is the last one that can be assigned.
- R5: In linear mode, a channel uses slots s and s+1. It sends the 16-bit word, bits 15..8 in slot s and bits 7..0 in slot s+1, most significant bit first, exactly as supplied, including the two sign-repeat bits 15 and 14.
- R6: Channel c transmits on highway `chTxHwy[c]`. A highway's `txOe` is high only during bits that belong to a channel assigned to that highway. Its `slotIndN` is low exactly while its `txOe` is high.
- R7: When several channels claim the same bit on the same highway, the lowest-numbered channel's data is sent.
- R8: Channel c samples the input `rxIn[chRxHwy[c]]` during its receive slot or slots. At the active edge that ends the word's last bit, the word is written to the channel's 16-bit `rxSample` field, and the channel's `rxValid` bit is high for exactly the following clock cycle. A companded word goes in the low byte, with the high byte zero.
- R9: Until the first frame sync, no output is driven and no word is received. A frame sync that arrives mid-frame restarts slot counting at once.
- R10: Reset brings `txOe` low, `slotIndN` high, `rxValid` low and `rxSample` to zero.
- R11: Each channel's transmit word is sampled at the frame-starting edge. Changes to `txSample` later in the frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLinear | input | 1 | 1: 16-bit linear words over two slots; 0: 8-bit companded |
| cfgHalfRate | input | 1 | 1: one serial bit per two bit-clock periods |
| cfgFallEdge | input | 1 | 1: falling bit-clock edge active; 0: rising |
| cfgOffset | input | OFS_W | Delay from frame sync to slot 0, in bit periods |
| chTxSlot | input | NUM_CH*SLOT_W | Transmit slot for each channel, channel c in field c |
| chRxSlot | input | NUM_CH*SLOT_W | Receive slot for each channel |
| chTxHwy | input | NUM_CH | Transmit highway select for each channel |
| chRxHwy | input | NUM_CH | Receive highway select for each channel |
| txSample | input | NUM_CH*16 | Transmit word for each channel |
| bitClk | input | 1 | Serial bit clock |
| frameSync | input | 1 | Frame sync, sampled on active edges |
| rxIn | input | 2 | Serial receive input of each highway |
| txOut | output | 2 | Serial transmit data of each highway |
| txOe | output | 2 | Drive enable of each transmit output (low = high impedance) |
| slotIndN | output | 2 | Active-low indicator that a highway is transmitting |
| rxSample | output | NUM_CH*16 | Last received word for each channel |
| rxValid | output | NUM_CH | One-cycle strobe for each channel when a new word is written |

## Verification
Every result is registered once behind the system-clock edge that sees the active bit-clock edge. So `txOut`, `txOe` and `slotIndN` for a new bit, and `rxValid` with its `rxSample` word, are all due one clock after that edge. The bench changes the bit clock, frame sync and receive data on a falling system-clock edge and reads the outputs on the next falling edge, exactly one rising edge later. At each active edge it compares the ports against values it works out from the edge count, using floor(edge/2) when half rate is selected and subtracting the configured delay.

// File: rtl/pcm_tsa_pkg.sv
package pcm_tsa_pkg;
  localparam int NUM_HWY = 2;
  localparam int LIN_W = 16;
  localparam int CMP_W = 8;
  localparam int IDX_W = $clog2(LIN_W);

  // control-to-datapath strobes, valid for one system clock
  typedef struct packed {
    logic frameStart;  // active edge that begins a frame
    logic advance;     // active edge that ends the current serial bit
    logic update;      // transmit outputs take the next bit
  } tsa_strobe_t;

  // per-channel result of matching the frame position against a slot
  typedef struct packed {
    logic             hit;   // position lies inside this channel's slot(s)
    logic             last;  // final bit of the channel's word
    logic [IDX_W-1:0] idx;   // word bit carried by this position
  } slot_hit_t;
endpackage

// File: rtl/pcm_tsa_ctrl.sv
module pcm_tsa_ctrl
  import pcm_tsa_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgHalfRate,
  input  logic             cfgFallEdge,
  input  logic             bitClk,
  input  logic             frameSync,
  output tsa_strobe_t      strb,
  output logic [CNT_W-1:0] curCnt,
  output logic [CNT_W-1:0] nxtCnt
);
  localparam logic [CNT_W-1:0] CNT_IDLE = '1;

  logic bclkQ;
  logic fsPrev;
  logic halfPh;
  logic tick;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    tick = cfgFallEdge ? (bclkQ & ~bitClk) : (~bclkQ & bitClk);
    strb.frameStart = tick & frameSync & ~fsPrev;
    // the counter parks at all-ones when no frame is running, which lies outside every slot
    strb.advance = tick & ~strb.frameStart & (~cfgHalfRate | halfPh) & (cnt != CNT_IDLE);
    strb.update = strb.frameStart | strb.advance;
  end

  assign curCnt = cnt;
  assign nxtCnt = strb.frameStart ? '0 : cnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bclkQ  <= 1'b0;
      fsPrev <= 1'b0;
      halfPh <= 1'b0;
      cnt    <= CNT_IDLE;
    end else begin
      bclkQ <= bitClk;
      if (tick) fsPrev <= frameSync;
      if (strb.frameStart) begin
        cnt    <= '0;
        halfPh <= 1'b0;
      end else if (tick) begin
        halfPh <= cfgHalfRate & ~halfPh;
        if (strb.advance) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcm_tsa_dp.sv
module pcm_tsa_dp
  import pcm_tsa_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 7,
  parameter int OFS_W  = 3,
  parameter int CNT_W  = SLOT_W + 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tsa_strobe_t               strb,
  input  logic [CNT_W-1:0]          curCnt,
  input  logic [CNT_W-1:0]          nxtCnt,
  input  logic                      cfgLinear,
  input  logic [OFS_W-1:0]          cfgOffset,
  input  logic [NUM_CH*SLOT_W-1:0]  chTxSlot,
  input  logic [NUM_CH*SLOT_W-1:0]  chRxSlot,
  input  logic [NUM_CH-1:0]         chTxHwy,
  input  logic [NUM_CH-1:0]         chRxHwy,
  input  logic [NUM_CH*LIN_W-1:0]   txSample,
  input  logic [NUM_HWY-1:0]        rxIn,
  output logic [NUM_HWY-1:0]        txOut,
  output logic [NUM_HWY-1:0]        txOe,
  output logic [NUM_CH*LIN_W-1:0]   rxSample,
  output logic [NUM_CH-1:0]         rxValid
);
  // frame position c versus slot s; the position excludes the programmed delay
  function automatic slot_hit_t decodeSlot(input logic [CNT_W-1:0] c,
                                           input logic [SLOT_W-1:0] s,
                                           input logic lin,
                                           input logic [OFS_W-1:0] ofs);
    slot_hit_t r;
    logic [CNT_W-1:0] pos;
    logic [SLOT_W:0]  diff;
    logic [2:0]       b;
    logic             inRange;
    pos     = c - CNT_W'(ofs);
    inRange = (c >= CNT_W'(ofs)) && !pos[CNT_W-1];
    diff    = {1'b0, pos[CNT_W-2:3]} - {1'b0, s};
    b       = pos[2:0];
    r.hit   = inRange && ((diff == '0) || (lin && (diff == (SLOT_W+1)'(1))));
    r.last  = (b == 3'd7) && (!lin || diff[0]);
    r.idx   = {lin && (diff == '0), ~b};
    return r;
  endfunction

  slot_hit_t          txHit   [NUM_CH];
  slot_hit_t          rxHit   [NUM_CH];
  logic [LIN_W-1:0]   txWord  [NUM_CH];
  logic [LIN_W-1:0]   wordNow [NUM_CH];
  logic [LIN_W-1:0]   rxShift [NUM_CH];
  logic [LIN_W-1:0]   rxWord  [NUM_CH];
  logic               rxStb   [NUM_CH];
  logic [NUM_HWY-1:0] rxQ;
  logic [NUM_HWY-1:0] selOn;
  logic [NUM_HWY-1:0] selBit;

  // value of each receive line just before the edge now being handled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxQ <= '0;
    else       rxQ <= rxIn;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic rxBit;
    assign txHit[g]   = decodeSlot(nxtCnt, chTxSlot[g*SLOT_W +: SLOT_W], cfgLinear, cfgOffset);
    assign rxHit[g]   = decodeSlot(curCnt, chRxSlot[g*SLOT_W +: SLOT_W], cfgLinear, cfgOffset);
    assign wordNow[g] = strb.frameStart ? txSample[g*LIN_W +: LIN_W] : txWord[g];
    assign rxBit      = rxQ[chRxHwy[g]];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        txWord[g]  <= '0;
        rxShift[g] <= '0;
        rxWord[g]  <= '0;
        rxStb[g]   <= 1'b0;
      end else begin
        rxStb[g] <= 1'b0;
        if (strb.frameStart) txWord[g] <= txSample[g*LIN_W +: LIN_W];
        if (strb.advance && rxHit[g].hit) begin
          rxShift[g] <= {rxShift[g][LIN_W-2:0], rxBit};
          if (rxHit[g].last) begin
            rxStb[g]  <= 1'b1;
            rxWord[g] <= cfgLinear ? {rxShift[g][LIN_W-2:0], rxBit}
                                   : {{(LIN_W-CMP_W){1'b0}}, rxShift[g][CMP_W-2:0], rxBit};
          end
        end
      end
    end

    assign rxSample[g*LIN_W +: LIN_W] = rxWord[g];
    assign rxValid[g]                 = rxStb[g];
  end

  // walk from the highest channel down so the lowest claimant is written last
  always_comb begin
    selOn  = '0;
    selBit = '0;
    for (int ch = NUM_CH - 1; ch >= 0; ch--) begin
      if (txHit[ch].hit) begin
        selOn[chTxHwy[ch]]  = 1'b1;
        selBit[chTxHwy[ch]] = wordNow[ch][txHit[ch].idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txOut <= '0;
      txOe  <= '0;
    end else if (strb.update) begin
      txOut <= selBit;
      txOe  <= selOn;
    end
  end
endmodule

// File: rtl/pcm_tsa.sv
module pcm_tsa
  import pcm_tsa_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int SLOT_W = 7,
  parameter int OFS_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgLinear,
  input  logic                     cfgHalfRate,
  input  logic                     cfgFallEdge,
  input  logic [OFS_W-1:0]         cfgOffset,
  input  logic [NUM_CH*SLOT_W-1:0] chTxSlot,
  input  logic [NUM_CH*SLOT_W-1:0] chRxSlot,
  input  logic [NUM_CH-1:0]        chTxHwy,
  input  logic [NUM_CH-1:0]        chRxHwy,
  input  logic [NUM_CH*LIN_W-1:0]  txSample,
  input  logic                     bitClk,
  input  logic                     frameSync,
  input  logic [NUM_HWY-1:0]       rxIn,
  output logic [NUM_HWY-1:0]       txOut,
  output logic [NUM_HWY-1:0]       txOe,
  output logic [NUM_HWY-1:0]       slotIndN,
  output logic [NUM_CH*LIN_W-1:0]  rxSample,
  output logic [NUM_CH-1:0]        rxValid
);
  localparam int CNT_W = SLOT_W + 4;

  tsa_strobe_t      strb;
  logic [CNT_W-1:0] curCnt;
  logic [CNT_W-1:0] nxtCnt;

  pcm_tsa_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgHalfRate(cfgHalfRate), .cfgFallEdge(cfgFallEdge),
    .bitClk(bitClk), .frameSync(frameSync), .strb(strb), .curCnt(curCnt), .nxtCnt(nxtCnt)
  );

  pcm_tsa_dp #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .OFS_W(OFS_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curCnt(curCnt), .nxtCnt(nxtCnt),
    .cfgLinear(cfgLinear), .cfgOffset(cfgOffset), .chTxSlot(chTxSlot), .chRxSlot(chRxSlot),
    .chTxHwy(chTxHwy), .chRxHwy(chRxHwy), .txSample(txSample), .rxIn(rxIn),
    .txOut(txOut), .txOe(txOe), .rxSample(rxSample), .rxValid(rxValid)
  );

  assign slotIndN = ~txOe;
endmodule

// File: rtl/pcm_tsa_chk.sv
module pcm_tsa_chk
  import pcm_tsa_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    bitClk,
  input logic                    cfgFallEdge,
  input tsa_strobe_t             strb,
  input logic [NUM_HWY-1:0]      txOe,
  input logic [NUM_CH-1:0]       rxValid,
  input logic [NUM_CH*LIN_W-1:0] rxSample
);
  logic seenSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                seenSync <= 1'b0;
    else if (strb.frameStart) seenSync <= 1'b1;
  end

  // R9: nothing is driven before the first frame start
  p_no_drive_unsynced_r9: assert property (@(posedge clk) disable iff (!rstN)
    !seenSync |-> (txOe == '0));

  // R2: a bit only ends on the selected bit-clock edge
  p_advance_on_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> (bitClk == !cfgFallEdge));

  // R6: a drive enable moves only when a new bit is launched
  p_oe_moves_on_update_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txOe) |-> $past(strb.update));

  // R8: a valid strobe follows the edge that ends a bit
  p_valid_after_advance_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid != '0) |-> $past(strb.advance));

  // R8: received words change only together with a valid strobe
  p_sample_with_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rxSample) |-> (rxValid != '0));
endmodule

bind pcm_tsa pcm_tsa_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .bitClk(bitClk), .cfgFallEdge(cfgFallEdge), .strb(strb),
  .txOe(txOe), .rxValid(rxValid), .rxSample(rxSample)
);

// File: tb/pcm_tsa_tb.sv
module pcm_tsa_tb;
  localparam int NCH = 8;
  localparam int SW  = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic cfgLinear = 1'b0, cfgHalfRate = 1'b0, cfgFallEdge = 1'b0;
  logic [2:0] cfgOffset = '0;
  logic [NCH*SW-1:0] chTxSlot = '0, chRxSlot = '0;
  logic [NCH-1:0] chTxHwy = '0, chRxHwy = '0;
  logic [NCH*16-1:0] txSample = '0;
  logic bitClk = 1'b0, frameSync = 1'b0;
  logic [1:0] rxIn = '0;
  logic [1:0] txOut, txOe, slotIndN;
  logic [NCH*16-1:0] rxSample;
  logic [NCH-1:0] rxValid;

  pcm_tsa u_dut (
    .clk(clk), .rstN(rstN), .cfgLinear(cfgLinear), .cfgHalfRate(cfgHalfRate),
    .cfgFallEdge(cfgFallEdge), .cfgOffset(cfgOffset), .chTxSlot(chTxSlot), .chRxSlot(chRxSlot),
    .chTxHwy(chTxHwy), .chRxHwy(chRxHwy), .txSample(txSample), .bitClk(bitClk),
    .frameSync(frameSync), .rxIn(rxIn), .txOut(txOut), .txOe(txOe), .slotIndN(slotIndN),
    .rxSample(rxSample), .rxValid(rxValid)
  );

  int nCheck = 0;
  int nFail = 0;
  int tSlot[NCH];
  int rSlot[NCH];
  bit tHwy[NCH];
  bit rHwy[NCH];
  logic [15:0] tWord[NCH];
  logic [15:0] snap[NCH];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic loadCfg();
    for (int ch = 0; ch < NCH; ch++) begin
      chTxSlot[ch*SW +: SW] = SW'(tSlot[ch]);
      chRxSlot[ch*SW +: SW] = SW'(rSlot[ch]);
      chTxHwy[ch] = tHwy[ch];
      chRxHwy[ch] = rHwy[ch];
      txSample[ch*16 +: 16] = tWord[ch];
    end
  endtask

  function automatic int cntOf(int e);
    return cfgHalfRate ? e / 2 : e;
  endfunction

  function automatic logic rxPat(int h, int c);
    int v;
    v = (c * 5 + h * 3) ^ (c >> 3);
    return v[1];
  endfunction

  // expected line state for highway h at frame count c (R1 R4 R5 R6 R7)
  task automatic expTx(int h, int c, output bit oe, output bit b);
    int pos, sl, bi, idx;
    oe = 1'b0;
    b = 1'b0;
    pos = c - int'(cfgOffset);
    if (pos < 0 || pos >= 1024) return;
    sl = pos / 8;
    bi = pos % 8;
    for (int ch = 0; ch < NCH; ch++) begin
      if (int'(tHwy[ch]) == h) begin
        idx = -1;
        if (cfgLinear) begin
          if (sl == tSlot[ch]) idx = 15 - bi;
          else if (sl == tSlot[ch] + 1) idx = 7 - bi;
        end else if (sl == tSlot[ch]) idx = 7 - bi;
        if (idx >= 0) begin
          oe = 1'b1;
          b = snap[ch][idx];
          return;
        end
      end
    end
  endtask

  function automatic bit expLast(int ch, int c);
    int pos;
    pos = c - int'(cfgOffset);
    if (pos < 0 || pos >= 1024 || pos % 8 != 7) return 1'b0;
    return cfgLinear ? (pos / 8 == rSlot[ch] + 1) : (pos / 8 == rSlot[ch]);
  endfunction

  function automatic logic [15:0] expRx(int ch);
    logic [15:0] w;
    int n;
    w = '0;
    n = cfgLinear ? 16 : 8;
    for (int i = 0; i < n; i++)
      w = {w[14:0], rxPat(int'(rHwy[ch]), rSlot[ch] * 8 + i + int'(cfgOffset))};
    return w;
  endfunction

  // one frame: frame sync on edge 0 (if enabled), checks after every active edge
  task automatic runFrame(int nEdges, bit withSync, bit scramble, string req);
    bit act, eo, eb;
    int c;
    logic [NCH-1:0] ev;
    act = !cfgFallEdge;
    @(negedge clk);
    loadCfg();
    bitClk = !act;
    @(negedge clk);
    for (int ch = 0; ch < NCH; ch++) snap[ch] = tWord[ch];
    for (int e = 0; e < nEdges; e++) begin
      @(negedge clk);
      bitClk = act;
      frameSync = withSync && (e == 0);
      rxIn[0] = rxPat(0, cntOf(e));
      rxIn[1] = rxPat(1, cntOf(e));
      if (scramble && e == 1) txSample = ~txSample;  // R11: late change must not leak
      @(negedge clk);
      c = cntOf(e);
      for (int h = 0; h < 2; h++) begin
        expTx(h, c, eo, eb);
        if (!withSync) eo = 1'b0;
        check(txOe[h] == eo && slotIndN[h] == !eo && (!eo || txOut[h] == eb), req,
              $sformatf("edge %0d hwy %0d oe/ind/data", e, h),
              {txOe[h], slotIndN[h], txOut[h]}, {eo, !eo, eb});
      end
      ev = '0;
      if (withSync && e > 0 && (!cfgHalfRate || e % 2 == 0))
        for (int ch = 0; ch < NCH; ch++) ev[ch] = expLast(ch, c - 1);
      check(rxValid == ev, req, $sformatf("edge %0d rxValid", e), rxValid, ev);
      for (int ch = 0; ch < NCH; ch++)
        if (ev[ch])
          check(rxSample[ch*16 +: 16] == expRx(ch), req, $sformatf("ch %0d rx word", ch),
                rxSample[ch*16 +: 16], expRx(ch));
      @(negedge clk);
      bitClk = !act;
      @(negedge clk);
    end
  endtask

  task automatic baseSlots();
    for (int ch = 0; ch < NCH; ch++) begin
      tSlot[ch] = (ch * 3) % 11;
      tHwy[ch] = ch[0];
      rSlot[ch] = (ch * 5 + 2) % 11;
      rHwy[ch] = ch[1];
      tWord[ch] = 16'hA5C3 ^ 16'(ch * 16'h1357);
    end
  endtask

  task automatic testReset();
    check(txOe == 2'b00, "R10", "txOe after reset", txOe, 0);
    check(slotIndN == 2'b11, "R10", "slotIndN after reset", slotIndN, 3);
    check(rxValid == '0, "R10", "rxValid after reset", rxValid, 0);
    check(rxSample == '0, "R10", "rxSample after reset", 0, 0);
  endtask

  task automatic testNoSync();
    baseSlots();
    runFrame(40, 1'b0, 1'b0, "R9 no sync");
  endtask

  task automatic testCompanded();
    cfgLinear = 0; cfgHalfRate = 0; cfgFallEdge = 0; cfgOffset = 0;
    baseSlots();
    runFrame(96, 1'b1, 1'b0, "R1 R4 R6 R8");
  endtask

  task automatic testOffsetEdge();
    baseSlots();
    cfgOffset = 3'd5; cfgFallEdge = 1;
    runFrame(100, 1'b1, 1'b0, "R1 R2 falling ofs5");
    cfgOffset = 3'd7; cfgFallEdge = 0;
    runFrame(100, 1'b1, 1'b0, "R1 R2 rising ofs7");
  endtask

  task automatic testLinear();
    cfgLinear = 1; cfgOffset = 3'd3;
    for (int ch = 0; ch < NCH; ch++) begin
      logic s;
      s = ch[0];
      tSlot[ch] = ch * 2;
      tHwy[ch] = ch[1];
      rSlot[ch] = (7 - ch) * 2;
      rHwy[ch] = ch[0];
      tWord[ch] = {s, s, s, 13'(ch * 1111 + 77)};
    end
    runFrame(136, 1'b1, 1'b0, "R5 linear");
    cfgLinear = 0;
  endtask

  task automatic testHalf();
    baseSlots();
    cfgHalfRate = 1; cfgOffset = 3'd2;
    runFrame(188, 1'b1, 1'b0, "R3 half rate");
    cfgHalfRate = 0;
  endtask

  task automatic testCollision();
    baseSlots();
    cfgOffset = 3'd1;
    for (int ch = 0; ch < NCH; ch++) begin
      tSlot[ch] = ch / 3;
      tHwy[ch] = ch[0];
    end
    runFrame(40, 1'b1, 1'b0, "R7 collision");
  endtask

  task automatic testRestart();
    baseSlots();
    cfgOffset = 3'd0;
    runFrame(40, 1'b1, 1'b1, "R9 R11 restart");
    runFrame(96, 1'b1, 1'b1, "R9 R11 restart");
  endtask

  task automatic testLastSlot();
    baseSlots();
    cfgOffset = 3'd0;
    for (int ch = 0; ch < NCH; ch++) begin
      tSlot[ch] = 127 - ch % 2;
      tHwy[ch] = 1'b0;
      rSlot[ch] = 127 - ch % 3;
    end
    runFrame(1028, 1'b1, 1'b0, "R4 R8 last slot");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoSync();
    testCompanded();
    testOffsetEdge();
    testLinear();
    testHalf();
    testCollision();
    testRestart();
    testLastSlot();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    nCheck++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end
endmodule